// File: doc/BRIEF.md
# Converter-Shared Bidirectional Port

This block is the control logic of an eight-pin bidirectional port whose pins double as analog converter inputs. Software reaches it over a narrow register interface. One address holds the output value latch and the other holds the direction register, where a 1 makes a pin an output. Each pin gets an output enable and an output value for its pad, and a read of the value register returns a mix of latched and live pin levels.

The analog converter supplies a 5-bit channel code. A code from 0 to 7 claims the pin with that index. The claimed pin loses its driver whatever the registers hold. A read of that pin's value bit never shows the pad level. It shows 0 when the pin's direction bit is 0, and the latched bit when the direction bit is 1. Register writes still land in the stored bits of a claimed pin, so its normal behaviour returns as soon as the converter moves to another channel. A code of 8 or more claims no pin.

Top module: `shared_gpio_port`

## Requirements
- R1: While reset is asserted, and after it is released, the value latch and direction register read 0 and every pin_oe bit is 0.
- R2: A bus write with bus_addr 0 loads bus_wdata into the value latch at the clock edge. A write with bus_addr 1 loads it into the direction register. Both take effect from the next cycle.
- R3: For a pin not claimed by the converter, pin_oe equals its direction bit and pin_out equals its latch bit.
- R4: With bus_addr 0, the read bit of an unclaimed pin is its latch bit when its direction bit is 1, and its pin_in level when its direction bit is 0.
- R5: A channel code k in 0 to 7 claims pin k. That pin has pin_oe 0 and pin_out 0 whatever its latch and direction bits hold.
- R6: With bus_addr 0, the read bit of the claimed pin is 0 when its direction bit is 0, whatever its pin_in level.
- R7: With bus_addr 0, the read bit of the claimed pin is its latch bit when its direction bit is 1.
- R8: Writes made while a pin is claimed update that pin's stored latch and direction bits. The stored values drive the pin once the claim ends.
- R9: A channel code of 8 or more claims no pin, and all eight pins follow R3 and R4.
- R10: With bus_addr 1, bus_rdata returns the whole direction register, claimed pin included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 1 | Register select: 0 value latch, 1 direction |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| adc_sel | input | 5 | Converter channel code |
| pin_in | input | 8 | Pad input levels |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |

## Verification
The assertions check several rules on every cycle:
- The claimed pin is never driven.
- The claimed pin's read bit ignores pad changes.
- Undriven pins read back their pad level when no pin is claimed.
- A direction write shows up on the enables in the next cycle.
- Reset clears all enables.

Only the bench's scenarios can show that stored bits survive a claim and come back when it ends. The same holds for the exact 0-or-latch choice on the claimed read bit, and for each code from 0 to 7 picking the pin with the matching index.

// File: rtl/gpio_share_pkg.sv
package gpio_share_pkg;
    localparam int DEF_PORT_W = 8;
    localparam int DEF_SEL_W  = 5;

    typedef enum logic {
        REG_VALUE = 1'b0,
        REG_DIR   = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/chan_decode.sv
module chan_decode #(
    parameter int PORT_W = 8,
    parameter int SEL_W  = 5
) (
    input  logic [SEL_W-1:0]  sel,
    output logic [PORT_W-1:0] claim
);
    // One comparator per pin; codes at or above PORT_W match nothing.
    for (genvar i = 0; i < PORT_W; i++) begin : g_cmp
        assign claim[i] = (sel == SEL_W'(i));
    end
endmodule

// File: rtl/port_regs.sv
module port_regs #(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              addr,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] latch,
    output logic [PORT_W-1:0] dir
);
    import gpio_share_pkg::*;

    typedef struct packed {
        logic [PORT_W-1:0] latch;
        logic [PORT_W-1:0] dir;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            if (reg_sel_e'(addr) == REG_DIR) st_d.dir   = wdata;
            else                             st_d.latch = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latch = st_q.latch;
    assign dir   = st_q.dir;
endmodule

// File: rtl/pin_mux.sv
module pin_mux #(
    parameter int PORT_W = 8
) (
    input  logic              addr,
    input  logic [PORT_W-1:0] latch,
    input  logic [PORT_W-1:0] dir,
    input  logic [PORT_W-1:0] claim,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] oe,
    output logic [PORT_W-1:0] out,
    output logic [PORT_W-1:0] rdata
);
    import gpio_share_pkg::*;

    logic [PORT_W-1:0] value_rd;

    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        always_comb begin
            oe[i]  = dir[i] & ~claim[i];
            out[i] = latch[i] & ~claim[i];
            if (dir[i])        value_rd[i] = latch[i];
            else if (claim[i]) value_rd[i] = 1'b0;
            else               value_rd[i] = pin_in[i];
        end
    end

    assign rdata = (reg_sel_e'(addr) == REG_DIR) ? dir : value_rd;
endmodule

// File: rtl/shared_gpio_port.sv
module shared_gpio_port #(
    parameter int PORT_W = gpio_share_pkg::DEF_PORT_W,
    parameter int SEL_W  = gpio_share_pkg::DEF_SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [SEL_W-1:0]  adc_sel,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] pin_out
);
    logic [PORT_W-1:0] latch_w, dir_w, claim_w;

    chan_decode #(.PORT_W(PORT_W), .SEL_W(SEL_W)) u_dec (
        .sel   (adc_sel),
        .claim (claim_w)
    );

    port_regs #(.PORT_W(PORT_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .latch (latch_w),
        .dir   (dir_w)
    );

    pin_mux #(.PORT_W(PORT_W)) u_mux (
        .addr   (bus_addr),
        .latch  (latch_w),
        .dir    (dir_w),
        .claim  (claim_w),
        .pin_in (pin_in),
        .oe     (pin_oe),
        .out    (pin_out),
        .rdata  (bus_rdata)
    );
endmodule

// File: rtl/shared_gpio_port_chk.sv
module shared_gpio_port_chk #(
    parameter int PORT_W = 8,
    parameter int SEL_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_addr,
    input logic [PORT_W-1:0] bus_wdata,
    input logic [PORT_W-1:0] bus_rdata,
    input logic [SEL_W-1:0]  adc_sel,
    input logic [PORT_W-1:0] pin_in,
    input logic [PORT_W-1:0] pin_oe,
    input logic [PORT_W-1:0] pin_out
);
    localparam int IDX_W = (PORT_W > 1) ? $clog2(PORT_W) : 1;

    logic             claimed;
    logic [IDX_W-1:0] idx;
    assign claimed = (int'(adc_sel) < PORT_W);
    assign idx     = adc_sel[IDX_W-1:0];

    a_r1_reset_no_drive: assert property (@(posedge clk)
        !rst_n |-> pin_oe == '0);

    a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr) |=> (claimed ? 1'b1 : (pin_oe == $past(bus_wdata))));

    a_r5_claim_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        claimed |-> (!pin_oe[idx] && !pin_out[idx]));

    a_r6_claim_read_ignores_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (claimed && !bus_addr && $stable(adc_sel) && $stable(bus_addr) && !$past(bus_wr))
        |-> $stable(bus_rdata[idx]));

    a_r9_undriven_reads_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (!claimed && !bus_addr) |-> (((bus_rdata ^ pin_in) & ~pin_oe) == '0));
endmodule

bind shared_gpio_port shared_gpio_port_chk #(.PORT_W(PORT_W), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .adc_sel   (adc_sel),
    .pin_in    (pin_in),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out)
);

// File: tb/test_shared_gpio_port.sv
module test_shared_gpio_port;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 13;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [4:0] adc_sel = 5'd31;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_oe, pin_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shared_gpio_port i_shared_gpio_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .adc_sel(adc_sel),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    // Fields: wr, addr, wdata, sel, pin, exp_oe, exp_out, exp_rd.
    // Expected values are those before the vector's own write lands.
    localparam logic [46:0] VEC [NV] = '{
        {1'b1,1'b1,8'hF0,5'd31,8'h5A,8'h00,8'h00,8'h00}, // R1 R10, load dir F0 (R2)
        {1'b1,1'b0,8'hA5,5'd31,8'h5A,8'hF0,8'h00,8'h0A}, // R3 R4, load latch A5
        {1'b0,1'b0,8'h00,5'd31,8'h3C,8'hF0,8'hA5,8'hAC}, // R3 R4
        {1'b0,1'b0,8'h00,5'd7 ,8'h0F,8'h70,8'h25,8'hAF}, // R5 R7 pin7
        {1'b0,1'b0,8'h00,5'd2 ,8'hFF,8'hF0,8'hA1,8'hAB}, // R5 R6 pin2
        {1'b1,1'b1,8'hFF,5'd2 ,8'hFF,8'hF0,8'hA1,8'hF0}, // R10, dir write while claimed
        {1'b0,1'b0,8'h00,5'd2 ,8'h00,8'hFB,8'hA1,8'hA5}, // R7 R8
        {1'b0,1'b1,8'h00,5'd2 ,8'h00,8'hFB,8'hA1,8'hFF}, // R10 R8
        {1'b1,1'b0,8'h0F,5'd2 ,8'h00,8'hFB,8'hA1,8'hA5}, // latch write while claimed
        {1'b0,1'b0,8'h00,5'd2 ,8'h00,8'hFB,8'h0B,8'h0F}, // R8 R5
        {1'b0,1'b0,8'h00,5'd8 ,8'h00,8'hFF,8'h0F,8'h0F}, // R9 R8 claim released
        {1'b1,1'b1,8'h00,5'd31,8'h00,8'hFF,8'h0F,8'hFF}, // R9, dir cleared
        {1'b0,1'b0,8'h00,5'd12,8'h96,8'h00,8'h0F,8'h96}  // R9 R4
    };

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic addr, input logic [7:0] wd,
                         input logic [4:0] sel, input logic [7:0] pin);
        @(negedge clk);
        bus_wr = wr; bus_addr = addr; bus_wdata = wd; adc_sel = sel; pin_in = pin;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #1;
        chk("R1", "oe in reset", pin_oe, 8'h00);
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][46], VEC[i][45], VEC[i][44:37], VEC[i][36:32], VEC[i][31:24]);
            chk($sformatf("R-vec%0d", i), "oe",  pin_oe,    VEC[i][23:16]);
            chk($sformatf("R-vec%0d", i), "out", pin_out,   VEC[i][15:8]);
            chk($sformatf("R-vec%0d", i), "rd",  bus_rdata, VEC[i][7:0]);
        end

        // R5 R7: each code 0..7 claims the matching pin
        drive(1'b1, 1'b1, 8'hFF, 5'd31, 8'h00);
        drive(1'b1, 1'b0, 8'hFF, 5'd31, 8'h00);
        for (int k = 0; k < 8; k++) begin
            drive(1'b0, 1'b0, 8'h00, 5'(k), 8'h00);
            chk("R5", "sweep oe",  pin_oe,    ~(8'h01 << k));
            chk("R5", "sweep out", pin_out,   ~(8'h01 << k));
            chk("R7", "sweep rd",  bus_rdata, 8'hFF);
        end

        // R1: reset in mid-run clears everything
        @(negedge clk); rst_n = 1'b0; bus_wr = 1'b0; #1;
        chk("R1", "oe after reset", pin_oe, 8'h00);
        chk("R1", "out after reset", pin_out, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        drive(1'b0, 1'b1, 8'h00, 5'd31, 8'h33);
        chk("R1", "dir reads 0", bus_rdata, 8'h00);
        drive(1'b0, 1'b0, 8'h00, 5'd31, 8'h33);
        chk("R1", "value reads pads", bus_rdata, 8'h33);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule